// File: doc/BRIEF.md
# Matrix Converter Switch Pattern Generator

This block drives the eight gate lines of a single-phase matrix converter built from four bidirectional switches. Each switch is two devices, `a` and `b`, one per current direction. The block works in one of two frequency-changing modes:

- **Step-down:** the output frequency is the line frequency divided by a ratio.
- **Step-up:** the output frequency is the line frequency multiplied by the same ratio.

All timing comes from counting system clock cycles. A line-frequency square wave marks the input half-cycles. Two output-frequency square waves mark the output half-cycles. The gate lines are a Boolean combination of the input polarity and the polarity of the selected output wave.

Mode and ratio are sampled only at an input half-cycle boundary. A change therefore never cuts an output pulse short. The gate lines are raw: dead time, isolation and drivers sit downstream. An illegal setting turns every gate off and raises a fault flag.

Top module: `mxc_switch_pattern`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight gate lines and `fault` are 0 after that edge.
- R2: The input polarity starts positive after reset. It inverts every `HALF_IN` clock cycles; with the default of 500000 and a 50 MHz clock this is a 50 Hz line.
- R3: No gate line goes high until the first full input half-cycle of `HALF_IN` clocks after reset has elapsed.
- R4: `mode_sel` and `ratio` take effect only at the clock where an input half-cycle ends; changes at any other time have no effect on the gate lines until that boundary.
- R5: Step-up mode (`mode_sel` = 2'b10) works on a step-up output polarity. Within each input half-cycle this polarity inverts exactly `ratio` times. After clock k of the half-cycle it inverts whenever floor(k·ratio/HALF_IN) increases, and the last inversion falls on the boundary.
- R6: Step-down mode (`mode_sel` = 2'b01) works on a step-down output polarity. This polarity inverts on every `ratio`-th input boundary and holds between boundaries.
- R7: When gating is active, exactly two gate lines are high. The gate bit order is s1a=0, s1b=1, s2a=2, s2b=3, s3a=4, s3b=5, s4a=6, s4b=7. The gates on for each pair of polarities are:
  - positive output, positive input: s1a and s4a (8'h41)
  - positive output, negative input: s2b and s3b (8'h28)
  - negative output, positive input: s2a and s3a (8'h14)
  - negative output, negative input: s1b and s4b (8'h82)
- R8: A mode code of 2'b00 or 2'b11, or a ratio of 0, sampled at a boundary, sets `fault` and holds all gate lines low until a later boundary samples a legal setting.
- R9: A boundary that samples a mode or ratio different from the active one restarts the step-down boundary count, so the next step-down inversion comes `ratio` boundaries later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 01 step-down, 10 step-up, others illegal |
| ratio | input | NR_W | Frequency ratio, legal 1..2^NR_W-1 and not above HALF_IN |
| gate | output | 8 | Raw gate lines, bit order as in R7 |
| fault | output | 1 | Illegal mode or ratio latched at the last boundary |

## Verification
The input counter and both output polarities show directly in the gate code, because each of the four legal codes names one pair of polarities.

A wrong line count moves every gate change off its expected clock within one half-cycle. A wrong accumulator in step-up mode shifts a single inversion inside the half-cycle, and the code then differs at that clock. A wrong step-down count, or a missed restart, becomes visible at the next boundary where an inversion is due or is wrongly taken.

The ports are compared to a behavioural model on every clock. Each fault therefore surfaces within at most one output half-cycle.

// File: rtl/mxc_pkg.sv
// Shared mode codes and gate bit positions for the switch pattern generator.
package mxc_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE     = 2'b00,
        MODE_STEPDOWN = 2'b01,
        MODE_STEPUP   = 2'b10,
        MODE_RSVD     = 2'b11
    } mode_e;

    localparam int GATE_N = 8;
    localparam int G_S1A  = 0;
    localparam int G_S1B  = 1;
    localparam int G_S2A  = 2;
    localparam int G_S2B  = 3;
    localparam int G_S3A  = 4;
    localparam int G_S3B  = 5;
    localparam int G_S4A  = 6;
    localparam int G_S4B  = 7;
endpackage

// File: rtl/mxc_line_timer.sv
// Line timer: counts HALF_IN clocks per input half-cycle and flips the
// input polarity at each boundary.
// Assumes HALF_IN >= 2. Polarity starts positive. 'armed' rises at the
// first boundary and stays high until reset.
module mxc_line_timer #(
    parameter int HALF_IN = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic line_pos,
    output logic armed
);
    localparam int CNT_W = $clog2(HALF_IN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_IN - 1);

    logic [CNT_W-1:0] cnt;

    // Boundary strobe on the last clock of each half-cycle.
    assign tick = (cnt == LAST);

    // Half-cycle counter, polarity flag and first-boundary arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            line_pos <= 1'b1;
            armed    <= 1'b0;
        end else if (tick) begin
            cnt      <= '0;
            line_pos <= ~line_pos;
            armed    <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R2
    AST_LINE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (line_pos != $past(line_pos))); // R2
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(line_pos)); // R2
endmodule

// File: rtl/mxc_up_wave.sv
// Step-up output wave: a fractional accumulator adds the ratio every clock
// and inverts the polarity each time the sum passes HALF_IN. This gives
// exactly 'nr' inversions per input half-cycle with no divider.
// Assumes nr <= HALF_IN and nr is constant between boundaries.
module mxc_up_wave #(
    parameter int HALF_IN = 500000,
    parameter int NR_W    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NR_W-1:0] nr,
    output logic            pol
);
    localparam int ACC_W = $clog2(HALF_IN + (1 << NR_W) + 1);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(HALF_IN);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;

    // Candidate sum for this clock.
    assign acc_sum = acc + ACC_W'(nr);

    // Accumulate, wrap and invert; resynchronise on every boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            pol <= 1'b1;
        end else if (tick) begin
            acc <= '0;
            pol <= ~pol;
        end else if (acc_sum >= LIMIT) begin
            acc <= acc_sum - LIMIT;
            pol <= ~pol;
        end else begin
            acc <= acc_sum;
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc < LIMIT); // R5
    AST_UP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pol != $past(pol))); // R5
endmodule

// File: rtl/mxc_down_wave.sv
// Step-down output wave: counts input boundaries and inverts the polarity
// on every nr-th one. 'restart' clears the count after the decision.
// Assumes nr is constant between boundaries.
module mxc_down_wave #(
    parameter int NR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            restart,
    input  logic [NR_W-1:0] nr,
    output logic            pol
);
    logic [NR_W-1:0] tcnt;
    logic [NR_W:0]   tnext;

    // Boundary count after this boundary.
    assign tnext = {1'b0, tcnt} + 1'b1;

    // Boundary counter with inversion and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
            pol  <= 1'b1;
        end else if (tick) begin
            if (tnext >= {1'b0, nr}) begin
                pol  <= ~pol;
                tcnt <= '0;
            end else begin
                tcnt <= tnext[NR_W-1:0];
            end
            if (restart) begin
                tcnt <= '0;
            end
        end
    end

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pol)); // R6
    AST_DN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart) |=> (tcnt == '0)); // R9
endmodule

// File: rtl/mxc_gate_decode.sv
// Gate decode: maps input and output polarity to the conducting switch
// pair. All lines stay low when 'enable' is low.
module mxc_gate_decode
    import mxc_pkg::*;
(
    input  logic              enable,
    input  logic              line_pos,
    input  logic              out_pos,
    output logic [GATE_N-1:0] gate
);
    // One switch pair per polarity combination.
    always_comb begin
        gate = '0;
        if (enable) begin
            unique case ({out_pos, line_pos})
                2'b11: begin gate[G_S1A] = 1'b1; gate[G_S4A] = 1'b1; end
                2'b10: begin gate[G_S3B] = 1'b1; gate[G_S2B] = 1'b1; end
                2'b01: begin gate[G_S2A] = 1'b1; gate[G_S3A] = 1'b1; end
                default: begin gate[G_S4B] = 1'b1; gate[G_S1B] = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/mxc_switch_pattern.sv
// Top: latches mode and ratio at input boundaries, runs the line timer and
// both output waves, and decodes the gate lines.
// Assumes ratio <= HALF_IN. Illegal settings turn gating off and raise
// 'fault' from the boundary that sampled them.
module mxc_switch_pattern
    import mxc_pkg::*;
#(
    parameter int HALF_IN = 500000,
    parameter int NR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [NR_W-1:0]   ratio,
    output logic [GATE_N-1:0] gate,
    output logic              fault
);
    logic            tick;
    logic            line_pos;
    logic            armed;
    logic            up_pol;
    logic            dn_pol;
    logic            out_pos;
    logic            restart;
    logic            cfg_legal;
    logic            enable;
    mode_e           mode_act;
    logic [NR_W-1:0] nr_act;

    // Legality and change detection of the incoming setting.
    assign cfg_legal = ((mode_e'(mode_sel) == MODE_STEPUP) ||
                        (mode_e'(mode_sel) == MODE_STEPDOWN)) && (ratio != '0);
    assign restart   = tick && ((mode_e'(mode_sel) != mode_act) || (ratio != nr_act));

    // Setting latch, updated only on an input boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_act <= MODE_IDLE;
            nr_act   <= '0;
            fault    <= 1'b0;
        end else if (tick) begin
            mode_act <= mode_e'(mode_sel);
            nr_act   <= ratio;
            fault    <= ~cfg_legal;
        end
    end

    mxc_line_timer #(.HALF_IN(HALF_IN)) u_line (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .line_pos(line_pos), .armed(armed)
    );

    mxc_up_wave #(.HALF_IN(HALF_IN), .NR_W(NR_W)) u_up (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nr(nr_act), .pol(up_pol)
    );

    mxc_down_wave #(.NR_W(NR_W)) u_down (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .nr(nr_act), .pol(dn_pol)
    );

    // Output polarity of the active mode and gating enable.
    assign out_pos = (mode_act == MODE_STEPUP) ? up_pol : dn_pol;
    assign enable  = armed && !fault;

    mxc_gate_decode u_dec (
        .enable(enable), .line_pos(line_pos), .out_pos(out_pos), .gate(gate)
    );

    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (gate == '0)); // R8
    AST_PAIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (gate != '0) |-> ($countones(gate) == 2)); // R7
    AST_NO_LEG_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate[G_S1A] && gate[G_S2A]) && !(gate[G_S3B] && gate[G_S4B])); // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(nr_act) && $stable(mode_act))); // R4
    AST_DARK_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (gate == '0)); // R3
endmodule

// File: tb/mxc_switch_pattern_bench.sv
module mxc_switch_pattern_bench;
    localparam int H = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic [3:0] ratio = 4'd5;
    logic [7:0] gate;
    logic       fault;

    int tests = 0;
    int fails = 0;
    bit checking = 1'b0;
    string phase = "R1";

    // behavioural model state
    int c, ip, up, dn, tc, armed, mode_a, nr_a, flt;

    always #5 clk = ~clk;

    mxc_switch_pattern #(.HALF_IN(H), .NR_W(4)) u_mxc_switch_pattern (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ratio(ratio),
        .gate(gate), .fault(fault)
    );

    // R7 pattern table: out positive/negative x input positive/negative
    function automatic logic [7:0] pattern(int lin, int outp);
        if (outp != 0 && lin != 0) return 8'h41;
        if (outp != 0)             return 8'h28;
        if (lin != 0)              return 8'h14;
        return 8'h82;
    endfunction

    function automatic logic [7:0] exp_gate();
        if (armed == 0 || flt != 0) return 8'h00;
        return pattern(ip, (mode_a == 2) ? up : dn);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // reference model step, one per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            c = 0; ip = 1; up = 1; dn = 1; tc = 0;
            armed = 0; mode_a = 0; nr_a = 0; flt = 0;
        end else if (c == H - 1) begin
            c = 0; ip ^= 1; armed = 1; up ^= 1;
            if (tc + 1 >= nr_a) begin dn ^= 1; tc = 0; end
            else tc++;
            if (int'(mode_sel) != mode_a || int'(ratio) != nr_a) tc = 0;
            mode_a = int'(mode_sel);
            nr_a = int'(ratio);
            flt = ((mode_a == 1 || mode_a == 2) && nr_a != 0) ? 0 : 1;
        end else begin
            if (((c + 1) * nr_a) / H > (c * nr_a) / H) up ^= 1;
            c++;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            chk(phase, gate, exp_gate());
            chk({phase, " fault"}, {7'b0, fault}, 8'(flt));
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        chk("R1 reset gates", gate, 8'h00);
        chk("R1 reset fault", {7'b0, fault}, 8'h00);
        rst_n = 1'b1;
        phase = "R3";
        checking = 1'b1;
        run(H - 1);
        chk("R3 dark before first boundary", gate, 8'h00);
        run(1);
        // first boundary: input negative, step-up polarity inverted to negative
        chk("R3 R7 first pattern", gate, 8'h82);
        phase = "R5 R2";
        run(4 * H);
        run(H / 2);
        ratio = 4'd3;
        phase = "R4";
        run(H / 2 - 2);
        phase = "R5 ratio3";
        run(4 * H);
        mode_sel = 2'b01; ratio = 4'd2;
        phase = "R6 ratio2";
        run(10 * H);
        ratio = 4'd5;
        phase = "R9 R6 ratio5";
        run(12 * H);
        mode_sel = 2'b00;
        phase = "R8 mode00";
        run(2 * H);
        chk("R8 fault raised", {7'b0, fault}, 8'h01);
        mode_sel = 2'b11;
        phase = "R8 mode11";
        run(2 * H);
        mode_sel = 2'b10; ratio = 4'd0;
        phase = "R8 ratio0";
        run(2 * H);
        chk("R8 gates off", gate, 8'h00);
        ratio = 4'd7;
        phase = "R8 recover";
        run(3 * H);
        chk("R8 fault cleared", {7'b0, fault}, 8'h00);
        checking = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule